// File: doc/BRIEF.md
# SDIO Card Interrupt Detector

This block is the host-side logic that turns an SDIO card interrupt into a CPU interrupt request. The card announces an interrupt by pulling DAT1 low and holding it there. The host, however, senses only the change of that line. The block brings the asynchronous DAT1 pin into the clock domain through a synchronizer chain. It then looks for a high-to-low transition and latches a sticky status bit when three things are true: the transition is seen, the interrupt-period qualifier is high, and the interrupt enable bit is set.

Because detection works on edges, a card interrupt that was already asserted before software set the enable produces no edge and is never latched. To cover that case, the block exposes the synchronized DAT1 level and the qualifier in a read-only level register. Software polls that register before it enables. The usual service order is to clear the status bit first and then clear the enable. This keeps the same card interrupt from being counted twice while the card-side clear is still outstanding.

Top module: `sdio_irq_detect`

## Requirements
- R1: While reset is held and on the first cycle after it, the status and enable registers read 0, the interrupt request is 0, and bit 0 of the level register reads 1 (an idle DAT1).
- R2: Bit 0 of the level register follows the DAT1 pin after the second rising clock edge that samples the new value. Bit 1 of the level register shows the interrupt-period qualifier in the same cycle. All other bits read 0.
- R3: A high-to-low change of DAT1 sets status bit 0 at the third rising edge after the pin first reads low, provided the qualifier was high and enable bit 0 was 1 at that edge.
- R4: A low-to-high change of DAT1, or a DAT1 level that stays constant, never sets the status bit.
- R5: A falling DAT1 edge that arrives while the qualifier is low leaves the status bit unchanged.
- R6: A falling DAT1 edge that arrives while enable bit 0 is 0 is not latched. A DAT1 line that is already low when the enable is written to 1 is not latched either.
- R7: A status write with data bit 0 equal to 1 clears the status bit at the next edge. A status write with data bit 0 equal to 0 leaves it unchanged. All other data bits are ignored.
- R8: If a qualifying falling edge and a clearing status write meet at the same clock edge, the status bit stays 1.
- R9: An enable write loads data bit 0 into the enable bit. The enable register reads that bit at position 0, and all of its other bits read 0. The same zero rule holds for bits above 0 of the status register.
- R10: The interrupt request is high exactly when both the status bit and the enable bit are 1. Clearing the enable drops the request in the next cycle and keeps the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dat1_pin | input | 1 | Asynchronous DAT1 line from the card |
| irq_period | input | 1 | High while the bus is in its interrupt period |
| sts_we | input | 1 | Write strobe for the status register |
| sts_wdata | input | DW | Status write data; bit 0 set to 1 clears the status bit |
| en_we | input | 1 | Write strobe for the enable register |
| en_wdata | input | DW | Enable write data; bit 0 is loaded into the enable bit |
| sts_rd | output | DW | Status register, bit 0 is the latched interrupt |
| en_rd | output | DW | Enable register, bit 0 is the enable |
| lvl_rd | output | DW | Level register: bit 0 synchronized DAT1, bit 1 qualifier |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
If the synchronizer or the edge register holds a wrong value, the status bit appears one cycle early or late, or not at all. The level register then disagrees with the pin's history within two cycles. If the sticky status flop is wrong, a wrongly lost or wrongly kept interrupt shows up on the request pin in the next cycle. A status that survives a clear or a masking write stays visible until the next write. The reference model compares every register and the request on every clock, so any such deviation surfaces in the cycle it first reaches a port.

// File: rtl/sdio_irq_pkg.sv
package sdio_irq_pkg;

    // Bit positions that software relies on
    localparam int STS_IRQ_BIT  = 0;
    localparam int EN_IRQ_BIT   = 0;
    localparam int LVL_DAT1_BIT = 0;
    localparam int LVL_PER_BIT  = 1;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2
    } line_edge_t;

    typedef struct packed {
        logic pending;
        logic enable;
    } irq_state_t;

    function automatic line_edge_t classify_edge(logic prev_lvl, logic cur_lvl);
        if (prev_lvl && !cur_lvl)
            return EDGE_FALL;
        else if (!prev_lvl && cur_lvl)
            return EDGE_RISE;
        return EDGE_NONE;
    endfunction

    function automatic logic next_pending(logic cur, logic set_hit, logic clr_hit);
        // a new event wins over a clear in the same cycle
        if (set_hit)
            return 1'b1;
        if (clr_hit)
            return 1'b0;
        return cur;
    endfunction

endpackage

// File: rtl/sdio_dat1_sync.sv
module sdio_dat1_sync
    import sdio_irq_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin,
    output logic       level,
    output line_edge_t edge_kind
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev_lvl;

    genvar g;
    generate
        for (g = 0; g <= LAST; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_lvl <= 1'b1;
        else     prev_lvl <= chain[LAST];
    end

    assign level     = chain[LAST];
    assign edge_kind = classify_edge(prev_lvl, chain[LAST]);

    // R4: a rise is only reported after the synchronized line was low
    a_r4_rise_after_low: assert property (@(posedge clk) disable iff (rst)
        (edge_kind == EDGE_RISE) |-> $past(level) == 1'b0);

endmodule

// File: rtl/sdio_irq_status.sv
module sdio_irq_status
    import sdio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_edge_t edge_kind,
    input  logic       period,
    input  logic       clr_hit,
    input  logic       en_we,
    input  logic       en_bit,
    output irq_state_t state
);
    logic set_hit;

    assign set_hit = (edge_kind == EDGE_FALL) && period && state.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '0;
        end else begin
            state.pending <= next_pending(state.pending, set_hit, clr_hit);
            if (en_we)
                state.enable <= en_bit;
        end
    end

    // R3: the status bit rises only after a qualified falling edge
    a_r3_set_needs_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(state.pending) |-> $past(edge_kind == EDGE_FALL && period && state.enable));

    // R5: no latch while the qualifier is low
    a_r5_no_set_outside_period: assert property (@(posedge clk) disable iff (rst)
        !period |=> !$rose(state.pending));

    // R6: no latch while disabled
    a_r6_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
        !state.enable |=> !$rose(state.pending));

    // R7: a clear without a competing event empties the status
    a_r7_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !(edge_kind == EDGE_FALL && period && state.enable)) |=> !state.pending);

    // R8: an event in the clear cycle keeps the status set
    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && edge_kind == EDGE_FALL && period && state.enable) |=> state.pending);

endmodule

// File: rtl/sdio_irq_detect.sv
module sdio_irq_detect
    import sdio_irq_pkg::*;
#(
    parameter int DW          = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dat1_pin,
    input  logic          irq_period,
    input  logic          sts_we,
    input  logic [DW-1:0] sts_wdata,
    input  logic          en_we,
    input  logic [DW-1:0] en_wdata,
    output logic [DW-1:0] sts_rd,
    output logic [DW-1:0] en_rd,
    output logic [DW-1:0] lvl_rd,
    output logic          irq_req
);
    logic       dat1_lvl;
    line_edge_t dat1_edge;
    irq_state_t st;
    logic       clr_hit;

    sdio_dat1_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin       (dat1_pin),
        .level     (dat1_lvl),
        .edge_kind (dat1_edge)
    );

    assign clr_hit = sts_we && sts_wdata[STS_IRQ_BIT];

    sdio_irq_status u_status (
        .clk       (clk),
        .rst       (rst),
        .edge_kind (dat1_edge),
        .period    (irq_period),
        .clr_hit   (clr_hit),
        .en_we     (en_we),
        .en_bit    (en_wdata[EN_IRQ_BIT]),
        .state     (st)
    );

    always_comb begin
        sts_rd               = '0;
        sts_rd[STS_IRQ_BIT]  = st.pending;
        en_rd                = '0;
        en_rd[EN_IRQ_BIT]    = st.enable;
        lvl_rd               = '0;
        lvl_rd[LVL_DAT1_BIT] = dat1_lvl;
        lvl_rd[LVL_PER_BIT]  = irq_period;
    end

    assign irq_req = st.pending && st.enable;

    // R10: masking the enable removes the request on the next cycle
    a_r10_mask_drops_req: assert property (@(posedge clk) disable iff (rst)
        (en_we && !en_wdata[EN_IRQ_BIT]) |=> !irq_req);

endmodule

// File: tb/sdio_irq_detect_test.sv
module sdio_irq_detect_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          dat1_pin = 1'b1;
    logic          irq_period = 1'b0;
    logic          sts_we = 1'b0;
    logic [DW-1:0] sts_wdata = '0;
    logic          en_we = 1'b0;
    logic [DW-1:0] en_wdata = '0;
    logic [DW-1:0] sts_rd, en_rd, lvl_rd;
    logic          irq_req;

    int vectors = 0;
    int errors  = 0;
    string phase = "R1";
    bit done = 1'b0;

    sdio_irq_detect #(.DW(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .dat1_pin(dat1_pin), .irq_period(irq_period),
        .sts_we(sts_we), .sts_wdata(sts_wdata), .en_we(en_we), .en_wdata(en_wdata),
        .sts_rd(sts_rd), .en_rd(en_rd), .lvl_rd(lvl_rd), .irq_req(irq_req)
    );

    always #4 clk = ~clk;

    // behavioural reference
    bit hist[$];
    bit m_sync = 1'b1, m_prev = 1'b1, m_sts = 1'b0, m_en = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            hist = {1'b1, 1'b1};
            m_sync = 1'b1; m_prev = 1'b1; m_sts = 1'b0; m_en = 1'b0;
        end else begin
            bit fell;
            fell = m_prev && !m_sync;
            if (fell && irq_period && m_en)      m_sts = 1'b1;
            else if (sts_we && sts_wdata[0])     m_sts = 1'b0;
            if (en_we) m_en = en_wdata[0];
            m_prev = m_sync;
            hist.push_back(dat1_pin);
            void'(hist.pop_front());
            m_sync = hist[0];
        end
    end

    task automatic cmp(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", phase, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (!done) begin
            cmp("status", sts_rd, {{(DW-1){1'b0}}, m_sts});
            cmp("enable", en_rd, {{(DW-1){1'b0}}, m_en});
            cmp("level", lvl_rd, {{(DW-2){1'b0}}, irq_period, m_sync});
            cmp("irq", {{(DW-1){1'b0}}, irq_req}, {{(DW-1){1'b0}}, m_sts && m_en});
        end
    end

    task automatic wait_cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_sts(logic [DW-1:0] d);
        @(negedge clk); sts_we = 1'b1; sts_wdata = d;
        @(negedge clk); sts_we = 1'b0; sts_wdata = '0;
    endtask

    task automatic wr_en(logic [DW-1:0] d);
        @(negedge clk); en_we = 1'b1; en_wdata = d;
        @(negedge clk); en_we = 1'b0; en_wdata = '0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        phase = "R1";
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);

        // R9: enable write, upper bits ignored
        phase = "R9";
        wr_en(32'hFFFF_FFFF);
        wait_cyc(1);

        // R2 / R3: qualified falling edge
        phase = "R3";
        irq_period = 1'b1;
        wait_cyc(1);
        dat1_pin = 1'b0;
        wait_cyc(5);

        // R7: write 0 keeps, write 1 clears
        phase = "R7";
        wr_sts(32'hFFFF_FFFE);
        wr_sts(32'h0000_0001);
        wait_cyc(1);

        // R4: rising edge and steady level do not set
        phase = "R4";
        dat1_pin = 1'b1;
        wait_cyc(6);

        // R5: fall outside the interrupt period
        phase = "R5";
        irq_period = 1'b0;
        dat1_pin = 1'b0;
        wait_cyc(5);
        irq_period = 1'b1;
        wait_cyc(3);
        dat1_pin = 1'b1;
        wait_cyc(4);

        // R6: fall while disabled, then pending level at enable time
        phase = "R6";
        wr_en(32'h0);
        dat1_pin = 1'b0;
        wait_cyc(5);
        wr_en(32'h1);
        wait_cyc(6);
        // R2: software sees the pending level
        phase = "R2";
        irq_period = 1'b0;
        wait_cyc(2);
        irq_period = 1'b1;
        dat1_pin = 1'b1;
        wait_cyc(4);

        // R8: clear meets a new event at the same edge
        phase = "R8";
        @(negedge clk); dat1_pin = 1'b0;
        @(negedge clk);
        @(negedge clk); sts_we = 1'b1; sts_wdata = 32'h1;
        @(negedge clk); sts_we = 1'b0; sts_wdata = '0;
        wait_cyc(3);

        // R10: masking drops the request and keeps the status
        phase = "R10";
        wr_en(32'h0);
        wait_cyc(3);
        wr_sts(32'h1);
        dat1_pin = 1'b1;
        wait_cyc(4);

        finish_run();
    end

endmodule